// File: doc/BRIEF.md
# External Memory Strobe Generator

This block produces the two strobes that a small 8-bit controller core uses to reach memory outside the chip: an address-latch strobe (high-going) that tells an external latch to capture the low address byte from a shared address/data bus, and an active-low read strobe for external program memory. Both are timed inside a machine cycle of twelve oscillator periods. The cycle is split into six states of two periods each.

The core tells the block, once per machine cycle, what that cycle is doing. One flag marks an external data access. One marks a code-table read. One says that code is fetched from external memory. A control bit asks for the address-latch strobe to be quiet. From these the block drops the pulses that an external data access does not use. It also holds the latch strobe idle when asked, unless code is running from outside. The current state and period are brought out for observation.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While `rst_n` is low: `ale`=0, `ale_drive`=1, `psen_n`=1, `state_o`=0 and `half_o`=0. After release, the first clock edge moves to state 0 period 1.
- R2: `state_o` counts 0..5 and `half_o` counts 0..1. Each clock advances `half_o`. State 5 period 1 wraps to state 0 period 0.
- R3: In an ordinary cycle `ale` is 1 for both periods of state 0 and of state 3, and 0 elsewhere. That is two pulses per cycle, one every six clocks. The exception is the cycle right after reset, where state 0 period 0 stays 0.
- R4: In a cycle flagged as an external data access (`movx_cyc`), the state-0 `ale` pulse is left out and the state-3 pulse is kept.
- R5: With `ext_exec`=1, `psen_n` is 0 in state 1 period 1, all of state 2, state 4 period 1 and all of state 5, and 1 elsewhere. With `ext_exec`=0, `psen_n` stays 1.
- R6: In a cycle flagged `movx_cyc`, both `psen_n` assertions are left out.
- R7: With `ale_dis`=1, `ext_exec`=0, `movx_cyc`=0 and `movc_cyc`=0, the whole cycle has `ale_drive`=0 and `ale`=1 (pin left high, not driven).
- R8: With `ale_dis`=1 in a cycle flagged `movx_cyc` or `movc_cyc`, `ale` pulses as in R3/R4 with `ale_drive`=1.
- R9: With `ext_exec`=1, `ale_dis` has no effect.
- R10: The flags are sampled at the clock edge that enters state 0 period 0 and are held for that cycle. Changes during the cycle have no effect until the next cycle.
- R11: `psen_n` is never 0 while `ale` is 1. Each `psen_n` assertion begins at least one period after `ale` has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| movx_cyc | input | 1 | Cycle is an external data access |
| movc_cyc | input | 1 | Cycle is a code-table read |
| ext_exec | input | 1 | Code is fetched from external memory |
| ale_dis | input | 1 | Request to keep the address-latch strobe quiet |
| ale | output | 1 | Address-latch strobe, active high |
| ale_drive | output | 1 | 1 when `ale` is actively driven, 0 when left pulled high |
| psen_n | output | 1 | External program read strobe, active low |
| state_o | output | ST_W (3) | Current state, 0..5 |
| half_o | output | SUB_W (1) | Current period within the state |

## Verification
The hardest situation to reach from the ports is a flag that changes partway through a machine cycle. Examples are an external data access raised just after the cycle boundary, or the quiet request dropped during a suppressed cycle. The outputs must follow the flags latched at the boundary and not the live pins. The random stimulus re-rolls the flags on random periods, so changes land at every state and period. The bench model latches them only at boundary edges. Directed cycles cover each flag combination held for whole cycles, and a reset applied in the middle of a cycle.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  // Per-machine-cycle qualifiers, latched at the cycle boundary
  typedef struct packed {
    logic movx;      // external data access
    logic movc;      // code-table read
    logic ext_exec;  // code fetched from outside
    logic ale_dis;   // quiet-latch-strobe request
  } cyc_flags_t;

  localparam int unsigned NUM_ALE_SLOTS = 2;
endpackage

// File: rtl/xbs_phase_ctr.sv
module xbs_phase_ctr #(
  parameter int unsigned STATES  = 6,
  parameter int unsigned PERIODS = 2,
  localparam int unsigned ST_W   = $clog2(STATES),
  localparam int unsigned SUB_W  = (PERIODS > 1) ? $clog2(PERIODS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [ST_W-1:0]  st_q,
  output logic [SUB_W-1:0] sub_q,
  output logic [ST_W-1:0]  st_nx,
  output logic [SUB_W-1:0] sub_nx,
  output logic             cyc_start_nx
);
  localparam logic [ST_W-1:0]  ST_LAST  = ST_W'(STATES - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PERIODS - 1);

  always_comb begin
    if (sub_q == SUB_LAST) begin
      sub_nx = '0;
      st_nx  = (st_q == ST_LAST) ? '0 : st_q + 1'b1;
    end else begin
      sub_nx = sub_q + 1'b1;
      st_nx  = st_q;
    end
    cyc_start_nx = (st_nx == '0) && (sub_nx == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      sub_q <= '0;
    end else begin
      st_q  <= st_nx;
      sub_q <= sub_nx;
    end
  end
endmodule

// File: rtl/xbs_cycle_flags.sv
module xbs_cycle_flags
  import xbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_start_nx,
  input  cyc_flags_t flags_in,
  output cyc_flags_t flags_nx
);
  cyc_flags_t flags_q;

  // Enable: only the edge that opens a new machine cycle loads the flags
  always_comb flags_nx = cyc_start_nx ? flags_in : flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (cyc_start_nx) flags_q <= flags_in;
  end
endmodule

// File: rtl/xbs_strobe_logic.sv
module xbs_strobe_logic
  import xbs_pkg::*;
#(
  parameter int unsigned STATES    = 6,
  parameter int unsigned PERIODS   = 2,
  parameter int unsigned ALE_ST_A  = 0,
  parameter int unsigned ALE_ST_B  = 3,
  parameter int unsigned MOVX_SKIP = 0,
  localparam int unsigned ST_W     = $clog2(STATES),
  localparam int unsigned SUB_W    = (PERIODS > 1) ? $clog2(PERIODS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ST_W-1:0]  st_nx,
  input  logic [SUB_W-1:0] sub_nx,
  input  cyc_flags_t       flags_nx,
  output logic             ale_q,
  output logic             ale_drv_q,
  output logic             psen_n_q
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PERIODS - 1);

  logic [NUM_ALE_SLOTS-1:0] win_ale, win_psen, slot_skip;
  logic ale_nx, ale_drv_nx, psen_n_nx, quiet;

  for (genvar g = 0; g < NUM_ALE_SLOTS; g++) begin : g_slot
    localparam int unsigned ANCHOR = (g == 0) ? ALE_ST_A : ALE_ST_B;
    // latch strobe covers the whole anchor state
    assign win_ale[g]   = (st_nx == ST_W'(ANCHOR));
    // read strobe starts in the last period of the following state
    assign win_psen[g]  = ((st_nx == ST_W'(ANCHOR + 1)) && (sub_nx == SUB_LAST)) ||
                          (st_nx == ST_W'(ANCHOR + 2));
    assign slot_skip[g] = flags_nx.movx && (g == MOVX_SKIP);
  end

  always_comb begin
    quiet      = flags_nx.ale_dis && !flags_nx.ext_exec &&
                 !flags_nx.movx && !flags_nx.movc;
    ale_drv_nx = !quiet;
    ale_nx     = quiet ? 1'b1 : |(win_ale & ~slot_skip);
    psen_n_nx  = !(flags_nx.ext_exec && !flags_nx.movx && |win_psen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q     <= 1'b0;
      ale_drv_q <= 1'b1;
      psen_n_q  <= 1'b1;
    end else begin
      ale_q     <= ale_nx;
      ale_drv_q <= ale_drv_nx;
      psen_n_q  <= psen_n_nx;
    end
  end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbs_pkg::*;
#(
  parameter int unsigned STATES   = 6,
  parameter int unsigned PERIODS  = 2,
  parameter int unsigned ALE_ST_A = 0,
  parameter int unsigned ALE_ST_B = 3,
  localparam int unsigned ST_W    = $clog2(STATES),
  localparam int unsigned SUB_W   = (PERIODS > 1) ? $clog2(PERIODS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             movx_cyc,
  input  logic             movc_cyc,
  input  logic             ext_exec,
  input  logic             ale_dis,
  output logic             ale,
  output logic             ale_drive,
  output logic             psen_n,
  output logic [ST_W-1:0]  state_o,
  output logic [SUB_W-1:0] half_o
);
  logic [ST_W-1:0]  st_nx;
  logic [SUB_W-1:0] sub_nx;
  logic             cyc_start_nx;
  cyc_flags_t       flags_in, flags_nx;

  always_comb begin
    flags_in.movx     = movx_cyc;
    flags_in.movc     = movc_cyc;
    flags_in.ext_exec = ext_exec;
    flags_in.ale_dis  = ale_dis;
  end

  xbs_phase_ctr #(.STATES(STATES), .PERIODS(PERIODS)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .st_q(state_o), .sub_q(half_o),
    .st_nx(st_nx), .sub_nx(sub_nx), .cyc_start_nx(cyc_start_nx)
  );

  xbs_cycle_flags u_flags (
    .clk(clk), .rst_n(rst_n), .cyc_start_nx(cyc_start_nx),
    .flags_in(flags_in), .flags_nx(flags_nx)
  );

  xbs_strobe_logic #(
    .STATES(STATES), .PERIODS(PERIODS),
    .ALE_ST_A(ALE_ST_A), .ALE_ST_B(ALE_ST_B), .MOVX_SKIP(0)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .st_nx(st_nx), .sub_nx(sub_nx),
    .flags_nx(flags_nx),
    .ale_q(ale), .ale_drv_q(ale_drive), .psen_n_q(psen_n)
  );
endmodule

// File: rtl/xbs_checker.sv
module xbs_checker #(
  parameter int unsigned STATES   = 6,
  parameter int unsigned PERIODS  = 2,
  parameter int unsigned ALE_ST_A = 0,
  parameter int unsigned ALE_ST_B = 3,
  localparam int unsigned ST_W    = $clog2(STATES),
  localparam int unsigned SUB_W   = (PERIODS > 1) ? $clog2(PERIODS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ale,
  input logic             ale_drive,
  input logic             psen_n,
  input logic [ST_W-1:0]  state_o,
  input logic [SUB_W-1:0] half_o
);
  localparam logic [ST_W-1:0]  ST_LAST  = ST_W'(STATES - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PERIODS - 1);

  logic in_ale_state;
  assign in_ale_state = (state_o == ST_W'(ALE_ST_A)) || (state_o == ST_W'(ALE_ST_B));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_levels: assert (!ale && ale_drive && psen_n && state_o == '0 && half_o == '0)
        else $error("reset levels wrong");
    end
  end

  a_r2_state_step: assert property (@(posedge clk) disable iff (!rst_n)
    (half_o == SUB_LAST && state_o != ST_LAST) |=> (state_o == $past(state_o) + 1'b1));

  a_r2_cycle_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (half_o == SUB_LAST && state_o == ST_LAST) |=> (state_o == '0 && half_o == '0));

  a_r3_ale_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && ale_drive) |-> in_ale_state);

  a_r5_psen_out_of_ale_state: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> !in_ale_state);

  a_r7_undriven_high: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_drive |-> ale);

  a_r10_drive_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ale_drive) |-> (state_o == '0 && half_o == '0));

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> !ale);

  a_r11_gap_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |-> !$past(ale));
endmodule

bind xbus_strobe_gen xbs_checker #(
  .STATES(STATES), .PERIODS(PERIODS), .ALE_ST_A(ALE_ST_A), .ALE_ST_B(ALE_ST_B)
) u_xbs_checker (
  .clk(clk), .rst_n(rst_n), .ale(ale), .ale_drive(ale_drive),
  .psen_n(psen_n), .state_o(state_o), .half_o(half_o)
);

// File: tb/test_xbus_strobe_gen.sv
`timescale 1ns/1ps
module test_xbus_strobe_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic movx_cyc = 1'b0, movc_cyc = 1'b0, ext_exec = 1'b0, ale_dis = 1'b0;
  logic ale, ale_drive, psen_n;
  logic [2:0] state_o;
  logic [0:0] half_o;

  int checks = 0;
  int errors = 0;
  int n = 0;            // clock edges since reset release
  logic in_reset = 1'b1;
  logic [3:0] mflags = '0;  // model's latched flags {movx, movc, ext_exec, ale_dis}
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  xbus_strobe_gen i_xbus_strobe_gen (
    .clk(clk), .rst_n(rst_n), .movx_cyc(movx_cyc), .movc_cyc(movc_cyc),
    .ext_exec(ext_exec), .ale_dis(ale_dis), .ale(ale), .ale_drive(ale_drive),
    .psen_n(psen_n), .state_o(state_o), .half_o(half_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", tag, what, act, exp, n);
    end
  endtask

  function automatic logic [3:0] live_flags();
    return {movx_cyc, movc_cyc, ext_exec, ale_dis};
  endfunction

  task automatic compare();
    int st, hf;
    logic m, c, x, d, quiet, e_ale, e_drv, e_psen;
    string t_ale, t_psen;
    if (in_reset || n == 0) begin
      check("R1", "ale", ale, 0);
      check("R1", "ale_drive", ale_drive, 1);
      check("R1", "psen_n", psen_n, 1);
      check("R1", "state", state_o, 0);
      check("R1", "half", half_o, 0);
      return;
    end
    st = (n / 2) % 6;
    hf = n % 2;
    {m, c, x, d} = mflags;
    quiet  = d && !x && !m && !c;
    e_drv  = !quiet;
    e_ale  = quiet ? 1'b1 : (((st == 0) && !m) || (st == 3));
    if (n == 1 && !quiet) e_ale = 1'b1;  // first S0P1 after release
    e_psen = !(x && !m && ((st == 1 && hf == 1) || st == 2 || (st == 4 && hf == 1) || st == 5));
    if (live_flags() != mflags)  t_ale = "R10";
    else if (quiet)              t_ale = "R7";
    else if (d && x)             t_ale = "R9";
    else if (d)                  t_ale = "R8";
    else if (m)                  t_ale = "R4";
    else                         t_ale = "R3";
    if (live_flags() != mflags)  t_psen = "R10";
    else if (m)                  t_psen = "R6";
    else                         t_psen = "R5";
    check("R2", "state", state_o, st);
    check("R2", "half", half_o, hf);
    check(t_ale, "ale", ale, e_ale);
    check(t_ale, "ale_drive", ale_drive, e_drv);
    check(t_psen, "psen_n", psen_n, e_psen);
    check("R11", "ale&read overlap", int'(ale && !psen_n), 0);
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) begin
      n++;
      in_reset = 1'b0;
      if (n % 12 == 0) mflags = live_flags();
    end
    @(negedge clk);
    compare();
  endtask

  task automatic set_flags(input logic [3:0] f);
    {movx_cyc, movc_cyc, ext_exec, ale_dis} = f;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_reset = 1'b1;
    #1;
    compare();               // R1: asynchronous effect
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    n = 0;
    mflags = '0;
    compare();
  endtask

  // hold flags for a number of whole cycles (first boundary latches them)
  task automatic run_cycles(input logic [3:0] f, input int ncyc);
    set_flags(f);
    repeat (ncyc * 12) step();
  endtask

  initial begin
    void'($urandom(32'h5EED_0B17));
    #1 rst_n = 1'b0;
    do_reset();
    // directed: {movx, movc, ext_exec, ale_dis}
    run_cycles(4'b0000, 3);  // R3 ordinary cycle
    run_cycles(4'b0010, 3);  // R5 external execution
    run_cycles(4'b1010, 3);  // R4 R6 external data access
    run_cycles(4'b0001, 3);  // R7 quiet strobe
    run_cycles(4'b1001, 2);  // R8 quiet request with data access
    run_cycles(4'b0101, 2);  // R8 quiet request with code-table read
    run_cycles(4'b0011, 2);  // R9 request ignored in external execution
    run_cycles(4'b1011, 2);  // R9 with data access
    // R10: change flags right after a boundary, then wait
    run_cycles(4'b0000, 1);
    step();
    set_flags(4'b1011);
    repeat (11) step();
    set_flags(4'b0001);
    repeat (13) step();
    // random: flags re-rolled on random periods
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) set_flags(4'($urandom_range(0, 15)));
      step();
    end
    // reset in the middle of a cycle
    repeat (5) step();
    do_reset();
    run_cycles(4'b0010, 2);
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 11) == 0) set_flags(4'($urandom_range(0, 15)));
      step();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule